// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Test Force Register

This block gathers interrupt requests for fifteen numbered levels (1 up to the `NLEVELS` parameter) and turns them into a single request level for the processor. A one-cycle pulse on a level's input latches a sticky pending bit. A mask register hides levels from the processor. While the test-enable input is high, a software force register is ORed into the pending set, so firmware can raise any level without a real source. The processor always sees the highest-numbered level that is not masked. It sees zero when nothing is active.

Software reaches four registers through one select field. The pending register is read-only. The mask and force registers can be read and written. The clear register is write-only. The processor acknowledges a level by presenting its number with a valid strobe. If the force bit of that level is being used in test mode, the acknowledge removes the force bit. In every other case it removes the pending bit. A write that sets any bit with no storage behind it raises a one-cycle parity-error pulse, so a corrupted bus word is flagged. There is no state machine: the block is a set of registers followed by a combinational priority encoder.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the pending and force registers are all zero. Mask bits 1 to NLEVELS-1 are all one, so a mask read returns 0x7FFE with the defaults. `irq_level` is 0 and `par_err` is 0.
- R2: A high on `irq_in[n]` in one cycle sets pending bit n at the next clock edge. The bit then stays set until a clear write or an acknowledge removes it.
- R3: The active set is (pending OR (force when `test_en`=1)) AND NOT mask. `irq_level` is the number of the highest active level, and 0 when no level is active. It follows the registers and `test_en` with no added clock delay.
- R4: The mask register holds levels 1 to NLEVELS-1 only, in bit positions equal to the level numbers. The top level (15) can never be masked.
- R5: A write with `reg_sel`=2 (clear) removes every pending bit whose `reg_wdata` bit is 1 and leaves the other pending bits unchanged. Reading select 2 returns 0.
- R6: An acknowledge (`ack_valid`=1 with `ack_level`=n, 1<=n<=NLEVELS) clears force bit n when `test_en`=1 and force bit n is set. In that case pending bit n is left as it is. Otherwise the acknowledge clears pending bit n. An acknowledge of level 0 has no effect.
- R7: A write with `reg_sel`=3 loads the force register (bits 15:1) only while `test_en`=1. With `test_en`=0 the write leaves the force register unchanged. The force register reads back on select 3.
- R8: `par_err` is high for exactly the cycle after a write that sets a reserved bit. For clear (2) and force (3) the reserved bits are bit 0 and bits 31:16. For mask (1) they are bit 0 and bits 31:15. The check applies to a force write even when `test_en`=0. A write to select 0 (pending) has no effect on any register and never raises `par_err`.
- R9: If a pulse on `irq_in[n]` arrives in the same cycle as a clear or an acknowledge of level n, pending bit n ends up set.
- R10: With `test_en`=0, set force bits do not reach `irq_level`, but they are kept and read back on select 3.
- R11: `reg_rdata` follows `reg_sel` combinationally: 0 gives pending, 1 gives mask, 2 gives 0 and 3 gives force. Bits with no storage behind them read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NLEVELS | One-cycle request pulses; bit n carries level n |
| test_en | input | 1 | Enables force-register writes and ORs the force register into the active set |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 pending, 1 mask, 2 clear, 3 force |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | LVL_W | Level being acknowledged |
| irq_level | output | LVL_W | Highest active level, or 0 when none is active |
| par_err | output | 1 | One-cycle pulse after a write that sets a reserved bit |

## Verification
The bench builds the block with its defaults, NLEVELS=15 and DATA_W=32. These values bring several boundaries into reach:
- the unmaskable level 15;
- the split between level 15 and bit 16 on clear and force writes;
- bit 15 being reserved on mask writes while it is legal on clear and force writes;
- a 4-bit acknowledge field that can name every level as well as the unused level 0.

A behavioural model of the three registers checks the request level, the read data and the error pulse on every clock. It is run through directed cases (priority between levels, force and acknowledge interplay, same-cycle collisions) and then through a long stretch of pseudo-random traffic with `test_en` toggling.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CLR  = 2'd2,
        SEL_FRC  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int NLEVELS = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NLEVELS:1]   set_in,
    input  logic [NLEVELS:1]   clr_in,
    input  logic [NLEVELS:1]   ack_in,
    input  logic               test_en,
    input  logic               frc_we,
    input  logic [NLEVELS:1]   frc_wdata,
    output logic [NLEVELS:1]   pend_q,
    output logic [NLEVELS:1]   frc_q
);

    logic [NLEVELS:1] pend_d;
    logic [NLEVELS:1] frc_d;

    // Per-level next-state: a new pulse beats any removal in the same cycle
    generate
        for (genvar n = 1; n <= NLEVELS; n++) begin : g_lvl
            logic ack_hits_frc;
            logic ack_hits_pend;
            assign ack_hits_frc  = ack_in[n] & test_en & frc_q[n];
            assign ack_hits_pend = ack_in[n] & ~ack_hits_frc;
            assign pend_d[n] = set_in[n] | (pend_q[n] & ~clr_in[n] & ~ack_hits_pend);
            assign frc_d[n]  = frc_we ? frc_wdata[n] : (frc_q[n] & ~ack_hits_frc);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            frc_q  <= '0;
        end else begin
            pend_q <= pend_d;
            frc_q  <= frc_d;
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int NLEVELS = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [NLEVELS-1:1]   wdata,
    output logic [NLEVELS-1:1]   mask_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (we) begin
            mask_q <= wdata;
        end
    end

endmodule

// File: rtl/irq_reg_guard.sv
module irq_reg_guard
    import irq_pkg::*;
#(
    parameter int NLEVELS = 15,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  reg_sel_e           sel,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic               par_err
);

    // Bit 0 and every bit above 'top' has no storage behind it
    function automatic logic [DATA_W-1:0] rsv_map(input int top);
        logic [DATA_W-1:0] r;
        for (int b = 0; b < DATA_W; b++) begin
            r[b] = (b == 0) || (b > top);
        end
        return r;
    endfunction

    localparam logic [DATA_W-1:0] RSV_CF = rsv_map(NLEVELS);
    localparam logic [DATA_W-1:0] RSV_MK = rsv_map(NLEVELS - 1);

    logic err_d;

    always_comb begin
        err_d = 1'b0;
        if (reg_wr) begin
            unique case (sel)
                SEL_CLR,
                SEL_FRC:  err_d = |(reg_wdata & RSV_CF);
                SEL_MASK: err_d = |(reg_wdata & RSV_MK);
                SEL_PEND: err_d = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_err <= 1'b0;
        end else begin
            par_err <= err_d;
        end
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NLEVELS = 15,
    parameter int LVL_W   = $clog2(NLEVELS + 1)
) (
    input  logic [NLEVELS:1]     pend,
    input  logic [NLEVELS:1]     frc,
    input  logic [NLEVELS-1:1]   mask,
    input  logic                 test_en,
    output logic [LVL_W-1:0]     level
);

    logic [NLEVELS:1] active;

    // The top level has no mask bit
    assign active = (pend | (frc & {NLEVELS{test_en}})) & ~{1'b0, mask};

    // Ascending scan: the last hit, the highest level, wins
    always_comb begin
        level = '0;
        for (int i = 1; i <= NLEVELS; i++) begin
            if (active[i]) begin
                level = LVL_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int NLEVELS = 15,
    parameter int DATA_W  = 32,
    localparam int LVL_W  = $clog2(NLEVELS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NLEVELS:1]     irq_in,
    input  logic                 test_en,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_sel,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 ack_valid,
    input  logic [LVL_W-1:0]     ack_level,
    output logic [LVL_W-1:0]     irq_level,
    output logic                 par_err
);

    reg_sel_e            sel;
    logic [NLEVELS:1]    ack_vec;
    logic [NLEVELS:1]    clr_vec;
    logic                frc_we;
    logic                mask_we;
    logic [NLEVELS:1]    pend_q;
    logic [NLEVELS:1]    frc_q;
    logic [NLEVELS-1:1]  mask_q;

    assign sel = reg_sel_e'(reg_sel);

    // Decode the acknowledged level into a one-hot vector
    generate
        for (genvar n = 1; n <= NLEVELS; n++) begin : g_ack
            assign ack_vec[n] = ack_valid && (ack_level == LVL_W'(n));
        end
    endgenerate

    assign clr_vec = (reg_wr && sel == SEL_CLR) ? reg_wdata[NLEVELS:1] : '0;
    assign frc_we  = reg_wr && (sel == SEL_FRC) && test_en;
    assign mask_we = reg_wr && (sel == SEL_MASK);

    irq_src_bank #(.NLEVELS(NLEVELS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_in    (irq_in),
        .clr_in    (clr_vec),
        .ack_in    (ack_vec),
        .test_en   (test_en),
        .frc_we    (frc_we),
        .frc_wdata (reg_wdata[NLEVELS:1]),
        .pend_q    (pend_q),
        .frc_q     (frc_q)
    );

    irq_mask_reg #(.NLEVELS(NLEVELS)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mask_we),
        .wdata  (reg_wdata[NLEVELS-1:1]),
        .mask_q (mask_q)
    );

    irq_reg_guard #(.NLEVELS(NLEVELS), .DATA_W(DATA_W)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .sel       (sel),
        .reg_wdata (reg_wdata),
        .par_err   (par_err)
    );

    irq_prio_enc #(.NLEVELS(NLEVELS), .LVL_W(LVL_W)) u_enc (
        .pend    (pend_q),
        .frc     (frc_q),
        .mask    (mask_q),
        .test_en (test_en),
        .level   (irq_level)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_PEND: reg_rdata[NLEVELS:1]   = pend_q;
            SEL_MASK: reg_rdata[NLEVELS-1:1] = mask_q;
            SEL_CLR:  reg_rdata              = '0;
            SEL_FRC:  reg_rdata[NLEVELS:1]   = frc_q;
        endcase
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_pkg::*;
#(
    parameter int NLEVELS = 15,
    localparam int LVL_W  = $clog2(NLEVELS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NLEVELS:1]     irq_in,
    input  logic                 test_en,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_sel,
    input  logic [NLEVELS:1]     wdata_lvl,
    input  logic                 ack_valid,
    input  logic [LVL_W-1:0]     ack_level,
    input  logic [LVL_W-1:0]     irq_level,
    input  logic                 par_err,
    input  logic [NLEVELS:1]     pend_q,
    input  logic [NLEVELS:1]     frc_q,
    input  logic [NLEVELS-1:1]   mask_q
);

    logic [NLEVELS:1] act;
    assign act = (pend_q | (frc_q & {NLEVELS{test_en}})) & ~{1'b0, mask_q};

    a_r2_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in != '0) |=> ((pend_q & $past(irq_in)) == $past(irq_in)));

    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> (irq_level == '0));

    a_r3_highest: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (({act, 1'b0} >> irq_level) == (NLEVELS + 1)'(1)));

    a_r4_top_unmaskable: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[NLEVELS] |-> (irq_level == LVL_W'(NLEVELS)));

    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_CLR) |=>
            ((pend_q & $past(wdata_lvl & ~irq_in)) == '0));

    a_r6_ack_force: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && test_en && ack_level != '0 && ack_level <= LVL_W'(NLEVELS)
         && frc_q[ack_level] && !(reg_wr && reg_sel == SEL_FRC))
            |=> !frc_q[$past(ack_level)]);

    a_r7_force_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> $stable(frc_q));

    a_r8_perr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> $past(reg_wr));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NLEVELS(NLEVELS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .test_en   (test_en),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .wdata_lvl (reg_wdata[NLEVELS:1]),
    .ack_valid (ack_valid),
    .ack_level (ack_level),
    .irq_level (irq_level),
    .par_err   (par_err),
    .pend_q    (pend_q),
    .frc_q     (frc_q),
    .mask_q    (mask_q)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:1] irq_in = '0;
    logic        test_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_level = '0;
    logic [3:0]  irq_level;
    logic        par_err;

    int    nchk = 0;
    int    nerr = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // Behavioural reference state (bit 0 never used)
    logic [15:0] m_pend, m_force, m_mask;
    logic        m_perr;

    always #10 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .test_en(test_en),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack_valid(ack_valid), .ack_level(ack_level),
        .irq_level(irq_level), .par_err(par_err)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 16'h0; m_force = 16'h0; m_mask = 16'h7FFE; m_perr = 1'b0;
        end else begin
            m_perr = reg_wr && ((((reg_sel == 2'd2) || (reg_sel == 2'd3)) &&
                                 ((reg_wdata & 32'hFFFF0001) != 0)) ||
                                ((reg_sel == 2'd1) && ((reg_wdata & 32'hFFFF8001) != 0)));
            if (ack_valid && ack_level != 0) begin
                if (test_en && m_force[ack_level]) m_force[ack_level] = 1'b0;
                else m_pend[ack_level] = 1'b0;
            end
            if (reg_wr) begin
                case (reg_sel)
                    2'd1: m_mask = reg_wdata[15:0] & 16'h7FFE;
                    2'd2: m_pend = m_pend & ~reg_wdata[15:0];
                    2'd3: if (test_en) m_force = reg_wdata[15:0] & 16'hFFFE;
                    default: ;
                endcase
            end
            m_pend = (m_pend | {irq_in, 1'b0}) & 16'hFFFE;
        end
    end

    function automatic logic [3:0] exp_lvl();
        logic [15:0] a;
        logic [3:0]  l;
        a = (m_pend | (test_en ? m_force : 16'h0)) & ~m_mask & 16'hFFFE;
        l = 4'd0;
        for (int i = 1; i <= 15; i++) if (a[i]) l = 4'(i);
        return l;
    endfunction

    function automatic logic [31:0] exp_rd();
        case (reg_sel)
            2'd0: return {16'h0, m_pend};
            2'd1: return {16'h0, m_mask};
            2'd3: return {16'h0, m_force};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk(cur_tag, "irq_level", {28'h0, irq_level}, {28'h0, exp_lvl()});
        chk(cur_tag, "par_err", {31'h0, par_err}, {31'h0, m_perr});
        chk(cur_tag, "reg_rdata", reg_rdata, exp_rd());
    endtask

    task automatic quiet();
        irq_in = '0; reg_wr = 1'b0; reg_wdata = '0; ack_valid = 1'b0; ack_level = '0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [15:1] v);
        irq_in = v; step(); irq_in = '0;
    endtask

    task automatic ack(input logic [3:0] n);
        ack_valid = 1'b1; ack_level = n; step(); ack_valid = 1'b0; ack_level = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        nerr++; nchk++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] lf;
        // R1 reset state
        cur_tag = "R1"; reg_sel = 2'd1;
        step(); step(); step();
        chk("R1", "mask after reset", reg_rdata, 32'h0000_7FFE);
        chk("R1", "level after reset", {28'h0, irq_level}, 32'h0);
        rst_n = 1'b1;
        step();
        reg_sel = 2'd0; step();
        chk("R1", "pending after reset", reg_rdata, 32'h0);

        // R2 latch while masked
        cur_tag = "R2";
        pulse(15'h0020 >> 1);
        step(); step();
        chk("R2", "pending bit 5 kept", reg_rdata, 32'h0000_0020);
        chk("R2", "masked level", {28'h0, irq_level}, 32'h0);

        // R4 top level ignores mask
        cur_tag = "R4";
        pulse(15'h4000);
        step();
        chk("R4", "level 15 unmaskable", {28'h0, irq_level}, 32'd15);
        wr(2'd1, 32'h0000_7FFE);
        step();

        // R5 clear
        cur_tag = "R5";
        wr(2'd2, 32'h0000_8020);
        reg_sel = 2'd2; step();
        reg_sel = 2'd0; step();
        chk("R5", "pending after clear", reg_rdata, 32'h0);

        // R3 priority with masking
        cur_tag = "R3";
        wr(2'd1, 32'h0);
        pulse(15'h0104);             // levels 3 and 9
        step();
        chk("R3", "highest of 3,9", {28'h0, irq_level}, 32'd9);
        wr(2'd1, 32'h0000_0200);
        step();
        chk("R3", "9 masked", {28'h0, irq_level}, 32'd3);
        reg_sel = 2'd1; step(); reg_sel = 2'd0;

        // R6 acknowledge
        cur_tag = "R6";
        ack(4'd3); step();
        chk("R6", "ack 3", {28'h0, irq_level}, 32'd0);
        ack(4'd0); step();
        wr(2'd1, 32'h0); step();
        chk("R6", "ack 0 no effect", {28'h0, irq_level}, 32'd9);
        ack(4'd9); step();

        // R7 force gated by test_en
        cur_tag = "R7"; reg_sel = 2'd3;
        wr(2'd3, 32'h0000_0010); step();
        chk("R7", "force locked", reg_rdata, 32'h0);
        test_en = 1'b1; step();
        wr(2'd3, 32'h0000_0110); step();
        chk("R7", "force loaded", reg_rdata, 32'h0000_0110);
        chk("R7", "forced level", {28'h0, irq_level}, 32'd8);

        // R10 force hidden without test_en
        cur_tag = "R10";
        test_en = 1'b0; step();
        chk("R10", "force hidden", {28'h0, irq_level}, 32'd0);
        chk("R10", "force kept", reg_rdata, 32'h0000_0110);
        test_en = 1'b1; step();

        // R6 ack removes force before pending
        cur_tag = "R6";
        pulse(15'h0080);             // level 8 pending too
        ack(4'd8); step();
        chk("R6", "force 8 cleared", reg_rdata, 32'h0000_0010);
        chk("R6", "pending 8 remains", {28'h0, irq_level}, 32'd8);
        ack(4'd8); step();
        chk("R6", "now level 4", {28'h0, irq_level}, 32'd4);
        test_en = 1'b0;
        ack(4'd4); step();
        test_en = 1'b1; step();
        chk("R6", "ack 4 without test_en keeps force", reg_rdata, 32'h0000_0010);
        wr(2'd3, 32'h0); test_en = 1'b0; step();

        // R8 reserved-bit errors
        cur_tag = "R8";
        wr(2'd2, 32'h0000_0001);
        chk("R8", "clear bit0", {31'h0, par_err}, 32'd1);
        step();
        chk("R8", "pulse one cycle", {31'h0, par_err}, 32'd0);
        wr(2'd1, 32'h0000_8000);
        chk("R8", "mask bit15", {31'h0, par_err}, 32'd1);
        wr(2'd3, 32'h0001_0000);
        chk("R8", "force bit16 test off", {31'h0, par_err}, 32'd1);
        wr(2'd2, 32'h0000_8000);
        chk("R8", "clear bit15 legal", {31'h0, par_err}, 32'd0);
        wr(2'd1, 32'h0000_0000); step();
        pulse(15'h0002);
        wr(2'd0, 32'hFFFF_FFFF);
        chk("R8", "pending write no error", {31'h0, par_err}, 32'd0);
        reg_sel = 2'd0; step();
        chk("R8", "pending write no effect", reg_rdata, 32'h0000_0004);

        // R9 pulse wins against clear and ack
        cur_tag = "R9";
        irq_in = 15'h0020; reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h0000_0040;
        step(); quiet(); reg_sel = 2'd0; step();
        chk("R9", "pulse beats clear", reg_rdata & 32'h40, 32'h40);
        irq_in = 15'h0020; ack_valid = 1'b1; ack_level = 4'd6;
        step(); quiet(); step();
        chk("R9", "pulse beats ack", reg_rdata & 32'h40, 32'h40);

        // R11 read mux across selects
        cur_tag = "R11";
        for (int s = 0; s < 4; s++) begin
            reg_sel = 2'(s); step();
        end

        // R3 pseudo-random traffic
        cur_tag = "R3";
        lf = 32'hACE1_2467;
        for (int c = 0; c < 3000; c++) begin
            for (int k = 0; k < 7; k++) lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            irq_in    = lf[15:1] & lf[31:17];
            reg_wr    = lf[3] & lf[7];
            reg_sel   = lf[9:8];
            reg_wdata = {(lf[20] & lf[21] & lf[22]) ? lf[31:16] : 16'h0,
                         lf[15:1], lf[2] & lf[4] & lf[6]};
            ack_valid = lf[11];
            ack_level = lf[27:24];
            test_en   = lf[13] | lf[14];
            step();
        end
        quiet();
        step();
        finish_run();
    end

endmodule